// File: doc/BRIEF.md
# I2C Start/Stop Condition Monitor

This block listens to the two wires of an I2C bus without ever driving them. It watches for the two bus framing events. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Two status bits record which of these events happened last. A bus-free output tells a would-be bus master whether it may claim the bus. A sticky interrupt flag is raised on every event, and software acknowledges it.

Both raw line inputs first pass through a two-stage synchronizer. They then pass through a per-line stability filter, so short spikes never look like bus events. Edge classification works on the filtered levels. When the module enable is dropped, the status bits are cleared. If the block is enabled in the middle of a transfer, it reports the bus as free. It raises nothing until the transfer's closing STOP arrives.

Top module: `i2c_cond_monitor`

## Requirements
- R1: A START (data line high to low while the clock line stays high) sets `start_seen` and clears `stop_seen`.
- R2: A STOP (data line low to high while the clock line stays high) sets `stop_seen` and clears `start_seen`.
- R3: `start_seen` and `stop_seen` are never high together. `bus_free` is high when `stop_seen` is high or both are low, and low when `start_seen` is high.
- R4: Every START or STOP sets `irq_flag`. A repeated START, seen while `start_seen` is already high, sets the flag again and leaves `start_seen` high.
- R5: `irq_flag` stays high until a cycle with `irq_ack` high clears it. When an event and `irq_ack` fall on the same cycle, the flag stays high.
- R6: `irq` is `irq_flag` gated by `irq_en`. When the block is enabled after a START, no flag is raised until the following STOP.
- R7: With `enable` low, both status bits read 0 from the next cycle on. START and STOP events change neither the status bits nor the flag.
- R8: After reset, `start_seen`, `stop_seen`, `irq_flag` and `irq` are 0 and `bus_free` is 1.
- R9: Changes of the data line while the clock line is low are not events and leave status and flag unchanged.
- R10: A level change on either line that lasts a single clock cycle is ignored. A level held for two or more cycles is accepted.
- R11: The status and flag outputs change on the fifth rising clock edge that samples a line change, counting the first edge that sees the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw I2C clock line level |
| sda_in | input | 1 | Raw I2C data line level |
| enable | input | 1 | Module enable; low clears the status bits |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the interrupt flag |
| start_seen | output | 1 | Last event was a START |
| stop_seen | output | 1 | Last event was a STOP |
| bus_free | output | 1 | Bus may be claimed |
| irq_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Flag gated by interrupt enable |

## Verification
A line change reaches the outputs after two synchronizer edges, two filter edges and one status edge. The outputs therefore move on the fifth rising edge that sees the new level. The bench drives every input on the falling edge. It waits a fixed settle of several cycles before it samples outputs on a falling edge, so each result is read well after it is due. For the latency and same-cycle acknowledge cases, the bench counts rising edges exactly. It checks that the outputs are still unchanged after the fourth edge and updated after the fifth, and it places `irq_ack` so that it meets the event on that fifth edge. A disable is due one edge after `enable` falls, and it is checked at the next falling edge.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    // Default filter and synchronizer depths.
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned HOLD_CYCLES_DEF = 2;

    // Number of bus lines observed.
    localparam int unsigned LINE_COUNT = 2;
    localparam int unsigned LINE_SCL   = 1;
    localparam int unsigned LINE_SDA   = 0;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef enum logic [1:0] {
        COND_NONE  = 2'b00,
        COND_START = 2'b01,
        COND_STOP  = 2'b10
    } cond_e;

    // Classify one step of the filtered lines.
    function automatic cond_e classify(input bus_lines_t prev, input bus_lines_t cur);
        cond_e res;
        res = COND_NONE;
        if (prev.scl && cur.scl) begin
            if (prev.sda && !cur.sda) begin
                res = COND_START;
            end else if (!prev.sda && cur.sda) begin
                res = COND_STOP;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Idle I2C lines are high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                chain[i] <= '1;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_deglitch.sv
module i2cmon_deglitch #(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_sync,
    output logic line_filt
);
    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] run_cnt;
    logic          filt_q;

    // Accept a new level only after it has differed for HOLD edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q  <= 1'b1;
            run_cnt <= '0;
        end else if (line_sync != filt_q) begin
            if (run_cnt == LAST) begin
                filt_q  <= line_sync;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign line_filt = filt_q;

    AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(line_sync))) // R10
        else $error("filtered level moved to a value the input did not hold");

endmodule

// File: rtl/i2cmon_detect.sv
module i2cmon_detect
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t cur,
    output cond_e      cond
);
    bus_lines_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= cur;
        end
    end

    always_comb begin
        cond = classify(prev_q, cur);
    end

endmodule

// File: rtl/i2cmon_status.sv
module i2cmon_status
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  irq_en,
    input  logic  irq_ack,
    input  cond_e cond,
    output logic  start_seen,
    output logic  stop_seen,
    output logic  bus_free,
    output logic  irq_flag,
    output logic  irq
);
    logic s_q, p_q, flag_q;
    logic event_live;

    assign event_live = enable && (cond != COND_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= 1'b0;
            p_q    <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (!enable) begin
                s_q <= 1'b0;
                p_q <= 1'b0;
            end else begin
                unique case (cond)
                    COND_START: begin s_q <= 1'b1; p_q <= 1'b0; end
                    COND_STOP:  begin s_q <= 1'b0; p_q <= 1'b1; end
                    default:    ;
                endcase
            end
            if (event_live) begin
                flag_q <= 1'b1;
            end else if (irq_ack) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign start_seen = s_q;
    assign stop_seen  = p_q;
    assign bus_free   = p_q | (~s_q & ~p_q);
    assign irq_flag   = flag_q;
    assign irq        = flag_q & irq_en;

    AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(s_q && p_q)) // R3
        else $error("both status bits high");
    AST_START_UPDATES: assert property (@(posedge clk) disable iff (rst)
        (enable && cond == COND_START) |=> (s_q && !p_q)) // R1
        else $error("start did not update status");
    AST_STOP_UPDATES: assert property (@(posedge clk) disable iff (rst)
        (enable && cond == COND_STOP) |=> (p_q && !s_q)) // R2
        else $error("stop did not update status");
    AST_EVENT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        event_live |=> flag_q) // R4
        else $error("event did not raise flag");
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !event_live) |=> !flag_q) // R5
        else $error("ack did not clear flag");
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!s_q && !p_q)) // R7
        else $error("disable did not clear status");
    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!enable && !flag_q) |=> !flag_q) // R7
        else $error("flag raised while disabled");

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2cmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned HOLD_CYCLES = HOLD_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic enable,
    input  logic irq_en,
    input  logic irq_ack,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq_flag,
    output logic irq
);
    logic [LINE_COUNT-1:0] raw_lines;
    logic [LINE_COUNT-1:0] sync_lines;
    logic [LINE_COUNT-1:0] filt_lines;
    bus_lines_t            filt_bus;
    cond_e                 cond;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2cmon_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINE_COUNT)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_filt
        i2cmon_deglitch #(
            .HOLD (HOLD_CYCLES)
        ) filt_i (
            .clk       (clk),
            .rst       (rst),
            .line_sync (sync_lines[g]),
            .line_filt (filt_lines[g])
        );
    end

    assign filt_bus.scl = filt_lines[LINE_SCL];
    assign filt_bus.sda = filt_lines[LINE_SDA];

    i2cmon_detect detect_i (
        .clk  (clk),
        .rst  (rst),
        .cur  (filt_bus),
        .cond (cond)
    );

    i2cmon_status status_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .irq_en     (irq_en),
        .irq_ack    (irq_ack),
        .cond       (cond),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free),
        .irq_flag   (irq_flag),
        .irq        (irq)
    );

endmodule

// File: tb/i2c_cond_monitor_tb.sv
module i2c_cond_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic clk = 1'b0;
    logic rst, scl_in, sda_in, enable, irq_en, irq_ack;
    logic start_seen, stop_seen, bus_free, irq_flag, irq;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cond_monitor dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .enable(enable), .irq_en(irq_en), .irq_ack(irq_ack),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_free(bus_free), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic lines(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic do_start();
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        lines(1'b0, scl_in ? 1'b0 : sda_in);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
    endtask

    task automatic t_reset();
        chk(start_seen, 1'b0, "R8 start_seen after reset");
        chk(stop_seen,  1'b0, "R8 stop_seen after reset");
        chk(irq_flag,   1'b0, "R8 irq_flag after reset");
        chk(irq,        1'b0, "R8 irq after reset");
        chk(bus_free,   1'b1, "R8 bus_free after reset");
    endtask

    // START with exact latency and an ack landing on the update edge.
    task automatic t_start_latency();
        @(negedge clk);
        sda_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(start_seen, 1'b0, "R11 no change after 4th edge");
        chk(irq_flag,   1'b0, "R11 flag not yet after 4th edge");
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        chk(start_seen, 1'b1, "R11/R1 start_seen after 5th edge");
        chk(stop_seen,  1'b0, "R1 stop_seen cleared");
        chk(irq_flag,   1'b1, "R5 event wins over same-cycle ack");
        chk(bus_free,   1'b0, "R3 bus busy after START");
        chk(irq,        1'b1, "R6 irq with irq_en high");
        @(posedge clk);
        @(negedge clk);
        chk(irq_flag,   1'b1, "R5 flag sticky without ack");
        ack();
        chk(irq_flag,   1'b0, "R5 ack clears flag");
    endtask

    task automatic t_data_bits();
        lines(1'b0, 1'b0);
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b0, 1'b1);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        chk(start_seen, 1'b1, "R9 data bits keep start_seen");
        chk(stop_seen,  1'b0, "R9 data bits give no STOP");
        chk(irq_flag,   1'b0, "R9 data bits raise no flag");
    endtask

    task automatic t_repeated_start();
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        chk(irq_flag,   1'b1, "R4 repeated START raises flag");
        chk(start_seen, 1'b1, "R4 repeated START keeps start_seen");
        chk(stop_seen,  1'b0, "R4 repeated START stop_seen low");
        ack();
    endtask

    task automatic t_stop();
        do_stop();
        chk(stop_seen,  1'b1, "R2 STOP sets stop_seen");
        chk(start_seen, 1'b0, "R2 STOP clears start_seen");
        chk(bus_free,   1'b1, "R3 bus free after STOP");
        chk(irq_flag,   1'b1, "R4 STOP raises flag");
        ack();
    endtask

    task automatic t_irq_mask();
        @(negedge clk);
        irq_en = 1'b0;
        do_start();
        chk(irq_flag, 1'b1, "R6 flag set while masked");
        chk(irq,      1'b0, "R6 irq masked");
        @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq,      1'b1, "R6 irq after unmask");
        ack();
        do_stop();
        ack();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        sda_in = 1'b0;
        @(negedge clk);
        sda_in = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk(start_seen, 1'b0, "R10 one-cycle SDA dip ignored");
        chk(irq_flag,   1'b0, "R10 one-cycle SDA dip no flag");
        @(negedge clk);
        scl_in = 1'b0;
        @(negedge clk);
        scl_in = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk(stop_seen,  1'b1, "R10 one-cycle SCL dip ignored");
        @(negedge clk);
        sda_in = 1'b0;
        repeat (2) @(negedge clk);
        sda_in = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk(start_seen, 1'b0, "R10 two-cycle dip then STOP");
        chk(stop_seen,  1'b1, "R10 two-cycle dip accepted as START+STOP");
        chk(irq_flag,   1'b1, "R10 accepted dip raises flag");
        ack();
    endtask

    task automatic t_disable();
        do_start();
        ack();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(start_seen, 1'b0, "R7 disable clears start_seen next cycle");
        chk(stop_seen,  1'b0, "R7 disable keeps stop_seen low");
        do_stop();
        chk(stop_seen,  1'b0, "R7 STOP ignored while disabled");
        chk(irq_flag,   1'b0, "R7 no flag while disabled");
        do_start();
        chk(start_seen, 1'b0, "R7 START ignored while disabled");
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_free,   1'b1, "R6 enabled mid-transfer reads free");
        chk(irq_flag,   1'b0, "R6 no flag before STOP");
        do_stop();
        chk(irq_flag,   1'b1, "R6 first flag at STOP");
        chk(stop_seen,  1'b1, "R6 stop_seen at STOP");
        ack();
    endtask

    initial begin
        rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1;
        enable = 1'b0; irq_en = 1'b0; irq_ack = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        irq_en = 1'b1;
        repeat (SETTLE) @(negedge clk);
        t_start_latency();
        t_data_bits();
        t_repeated_start();
        t_stop();
        t_irq_mask();
        t_glitch();
        t_disable();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule